// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address stream for a four-beat burst into a synchronous burst memory. A burst opens when either of two address strobes, one driven from the processor side and one from the controller side, is high at a rising clock edge. The full input address is captured at that edge and becomes the first beat. After that, each rising edge with the advance input high steps the two low address bits to the next beat of the burst. The upper address bits stay at their captured value.

A static mode input picks the burst order. In interleaved order the low bits of beat n are the start low bits XOR n. In linear order they are the start low bits plus n, modulo four. A last-beat flag marks the fourth address of the burst. The beat counter is two bits wide, so advancing past the fourth beat wraps back to the first.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is active (rst_n low), and after reset until the first strobe, addr_out is all zeros and last_beat is 0.
- R2: When proc_strobe is high at a rising edge, addr_out equals the addr_in sampled at that edge from that edge onward, and last_beat is 0 (beat 0).
- R3: When ctrl_strobe alone is high at a rising edge, it loads the address exactly as proc_strobe does.
- R4: With linear_mode = 0 (interleaved), the low two bits of addr_out on beat n are start[1:0] XOR n, for n = 0..3.
- R5: With linear_mode = 1 (linear), the low two bits of addr_out on beat n are (start[1:0] + n) mod 4, for n = 0..3.
- R6: On an edge where neither strobe nor adv is high, addr_out and last_beat keep their values.
- R7: When a strobe and adv are both high at the same edge, the strobe wins: the new address is loaded at beat 0 and no step occurs.
- R8: addr_out[AW-1:2] stays equal to the captured upper bits on every beat of a burst.
- R9: last_beat is 1 exactly on beat 3, the fourth address of a burst, and 0 on beats 0 to 2.
- R10: An adv on beat 3 wraps the burst to beat 0, which restores the start address and clears last_beat.
- R11: adv high before any strobe since reset has no effect: addr_out stays zero and last_beat stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | AW | Start address, captured when a strobe is sampled |
| proc_strobe | input | 1 | Processor-side address strobe, active high |
| ctrl_strobe | input | 1 | Controller-side address strobe, active high |
| adv | input | 1 | Step to the next beat of the burst |
| linear_mode | input | 1 | 0 selects interleaved order, 1 selects linear order |
| addr_out | output | AW | Current burst address |
| last_beat | output | 1 | High on the fourth address of a burst |

## Verification
Each result is due one edge after its stimulus. A strobe sampled at edge k shows the start address from edge k onward, and an advance sampled at edge k shows the next beat from edge k onward. The bench drives inputs on the falling edge and makes each check on the next falling edge, after the single register has updated. The corner-case tasks use the same timing: a wrap past beat 3, a strobe and advance in the same cycle, idle cycles, and advances before any load.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          proc_strobe,
  input  logic          ctrl_strobe,
  input  logic          adv,
  input  logic          linear_mode,
  output logic [AW-1:0] addr_out,
  output logic          last_beat
);
  localparam int HW = AW - 2;

  logic [HW-1:0] hi_q;
  logic [1:0]    base_q;
  logic [1:0]    beat_q;
  logic          live_q;
  logic          load;
  logic [1:0]    low;

  assign load = proc_strobe | ctrl_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      beat_q <= '0;
      live_q <= 1'b0;
    end else if (load) begin
      hi_q   <= addr_in[AW-1:2];
      base_q <= addr_in[1:0];
      beat_q <= '0;
      live_q <= 1'b1;
    end else if (adv && live_q) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  assign low       = linear_mode ? (base_q + beat_q) : (base_q ^ beat_q);
  assign addr_out  = {hi_q, low};
  assign last_beat = live_q && (beat_q == 2'd3);
endmodule

module burst_addr_gen_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr_in,
  input logic          proc_strobe,
  input logic          ctrl_strobe,
  input logic          adv,
  input logic          linear_mode,
  input logic [AW-1:0] addr_out,
  input logic          last_beat
);
  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe || ctrl_strobe) |=> (addr_out == $past(addr_in)) && !last_beat);

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe && !ctrl_strobe && !adv) ##1 $stable(linear_mode)
      |-> $stable(addr_out) && $stable(last_beat));

  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe && !ctrl_strobe) |=> $stable(addr_out[AW-1:2]));

  a_r10_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && adv && !proc_strobe && !ctrl_strobe) |=> !last_beat);

  a_r9_last_steps_once: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last_beat) |-> $past(adv) && !$past(proc_strobe) && !$past(ctrl_strobe));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .proc_strobe(proc_strobe),
  .ctrl_strobe(ctrl_strobe), .adv(adv), .linear_mode(linear_mode),
  .addr_out(addr_out), .last_beat(last_beat)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          proc_strobe = 1'b0;
  logic          ctrl_strobe = 1'b0;
  logic          adv = 1'b0;
  logic          linear_mode = 1'b0;
  logic [AW-1:0] addr_out;
  logic          last_beat;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_addr_gen #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .proc_strobe(proc_strobe),
    .ctrl_strobe(ctrl_strobe), .adv(adv), .linear_mode(linear_mode),
    .addr_out(addr_out), .last_beat(last_beat)
  );

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] s, int n, logic lin);
    logic [1:0] lo;
    lo = lin ? 2'(s[1:0] + 2'(n)) : (s[1:0] ^ 2'(n));
    return {s[AW-1:2], lo};
  endfunction

  task automatic check(string req, logic [AW-1:0] ea, logic el);
    checks++;
    if (addr_out !== ea || last_beat !== el) begin
      fails++;
      $display("FAIL %s: addr_out=%h last=%b expected addr_out=%h last=%b",
               req, addr_out, last_beat, ea, el);
    end
  endtask

  task automatic tick(logic ps, logic cs, logic a, logic [AW-1:0] ad);
    proc_strobe = ps; ctrl_strobe = cs; adv = a; addr_in = ad;
    @(negedge clk);
    proc_strobe = 0; ctrl_strobe = 0; adv = 0; addr_in = '0;
  endtask

  task automatic run_burst(string req, logic [AW-1:0] s, logic use_ctrl, logic lin);
    linear_mode = lin;
    tick(!use_ctrl, use_ctrl, 1'b0, s);
    check({req, " beat0 R2/R3"}, expect_addr(s, 0, lin), 1'b0);
    for (int n = 1; n < 4; n++) begin
      tick(0, 0, 1, '0);
      check({req, " step R8/R9"}, expect_addr(s, n, lin), n == 3);
    end
    tick(0, 0, 1, '0);
    check({req, " wrap R10"}, expect_addr(s, 0, lin), 1'b0);
  endtask

  task automatic t_reset_r1();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", '0, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", '0, 1'b0);
  endtask

  task automatic t_adv_before_load_r11();
    tick(0, 0, 1, 18'h2AAAA);
    tick(0, 0, 1, '0);
    check("R11 adv before load", '0, 1'b0);
  endtask

  task automatic t_hold_r6();
    logic [AW-1:0] s = 18'h1C3C2;
    linear_mode = 0;
    tick(1, 0, 0, s);
    tick(0, 0, 1, '0);
    repeat (3) tick(0, 0, 0, 18'h3FFFF);
    check("R6 idle hold", expect_addr(s, 1, 0), 1'b0);
  endtask

  task automatic t_priority_r7();
    logic [AW-1:0] s = 18'h0F0F1;
    logic [AW-1:0] t = 18'h23456;
    linear_mode = 1;
    tick(0, 1, 0, s);
    tick(0, 0, 1, '0);
    tick(1, 0, 1, t);
    check("R7 strobe beats adv", expect_addr(t, 0, 1), 1'b0);
    tick(1, 1, 1, s);
    check("R7 both strobes with adv", expect_addr(s, 0, 1), 1'b0);
  endtask

  task automatic t_reload_midburst_r2();
    logic [AW-1:0] s = 18'h00003;
    linear_mode = 0;
    tick(1, 0, 0, 18'h12340);
    tick(0, 0, 1, '0);
    tick(0, 0, 1, '0);
    tick(0, 0, 1, '0);
    check("R9 last before reload", expect_addr(18'h12340, 3, 0), 1'b1);
    tick(0, 1, 0, s);
    check("R2 reload clears last", s, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset_r1();
    t_adv_before_load_r11();
    for (int k = 0; k < 4; k++) begin
      run_burst("R4 interleaved", {14'h2A5C, 2'(k)}, k[0], 1'b0);
      run_burst("R5 linear", {14'h1357, 2'(k)}, !k[0], 1'b1);
    end
    t_hold_r6();
    t_priority_r7();
    t_reload_midburst_r2();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule